// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial-clock timing for an I2C bus master from the fast system clock. A prescaler divides the system clock by one to four. The result is a one-cycle internal tick enable. A phase sequencer counts those ticks to shape each SCL period into a driven-low half and a released-high half. The sequencer raises the open-drain pull-down output for the low half. It also emits two strobes for the byte engine: one in the middle of the low half, where SDA may change, and one in the middle of the high half, where SDA is sampled.

The timing comes from an 8-bit divider byte written over the register bus. Bits [1:0] hold the prescale selector and bits [7:2] hold the period field. One SCL period lasts 20 + 8 x field internal ticks. The sensed SCL line is folded into the period. After the sequencer releases SCL, it waits for the line to read high before it counts the high half. A slow rise, or a target holding the clock low, therefore lengthens the period by exactly the ticks spent waiting.

The enable input doubles as the busy indication. A written byte is held in a staging register and only reaches the live timing while the generator is disabled. This means a transfer in flight never sees its clock change. Choosing field values for a target bus speed, and keeping the internal tick below 20 MHz, is left to software.

Top module: `scl_clk_gen`

## Requirements
- R1: The divider byte is decoded with the prescale selector in bits [1:0] and the period field in bits [7:2].
- R2: While enabled, `ick_pulse` is high for one cycle in every (selector + 1) system clocks.
- R3: With SCL rising at once on release, one SCL period (rising edge to rising edge of `scl_pull_low`) lasts (selector + 1) x (20 + 8 x field) system clocks. This holds for fields 0 and 63 alike.
- R4: In each period, `scl_pull_low` is high for exactly (selector + 1) x (10 + 4 x field) system clocks.
- R5: `tick_mid_low` pulses exactly once per period, and only while `scl_pull_low` is high.
- R6: `tick_mid_high` pulses exactly once per period, and only while SCL is released and `scl_sense` reads high.
- R7: After SCL is released, each internal tick on which `scl_sense` still reads low adds one tick to the period.
- R8: While `gen_en` is low, `scl_pull_low`, `ick_pulse` and both strobes stay low. The first cycle after `gen_en` rises begins a low half.
- R9: A divider byte written while `gen_en` is high leaves the running period unchanged, and it takes effect once `gen_en` has been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the divider byte |
| cfg_wdata | input | 8 | Divider byte: [1:0] prescale selector, [7:2] period field |
| gen_en | input | 1 | Generator enable; high means a transfer is running |
| scl_sense | input | 1 | Sensed level of the SCL line |
| scl_pull_low | output | 1 | 1 drives SCL low, 0 releases it |
| ick_pulse | output | 1 | Internal tick enable |
| tick_mid_low | output | 1 | Strobe in the middle of the low half |
| tick_mid_high | output | 1 | Strobe in the middle of the high half |

## Verification
A wrong prescale count or half-period count shows up within one SCL period, as a period or low-half length that is off by a multiple of the tick spacing. A sequencer stuck in its rise wait shows as `scl_pull_low` never rising again, which is caught on the next period measurement. A misplaced or repeated strobe shows as a per-period strobe count other than one, or as a strobe seen in the wrong half. A configuration that leaks through while the generator is enabled shows as a changed period before `gen_en` has dropped.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int DEF_PSC_W = 2;
  localparam int DEF_DIV_W = 6;
  localparam int DEF_BASE  = 20;
  localparam int DEF_STEP  = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_RISE = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;
endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold #(
  parameter int PSC_W = 2,
  parameter int DIV_W = 6,
  parameter int BASE  = 20,
  parameter int STEP  = 8,
  parameter int CNT_W = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [PSC_W+DIV_W-1:0] cfg_wdata,
  input  logic                   gen_en,
  output logic [PSC_W-1:0]       act_psc,
  output logic [CNT_W-1:0]       half_len,
  output logic [CNT_W-1:0]       mid_pt
);
  localparam int CFG_W     = PSC_W + DIV_W;
  localparam int HALF_BASE = BASE / 2;
  localparam int HALF_STEP = STEP / 2;

  logic [CFG_W-1:0] staged_q, staged_d;
  logic [CFG_W-1:0] live_q, live_d;
  logic [DIV_W-1:0] act_div;

  always_comb begin
    staged_d = staged_q;
    if (cfg_we) staged_d = cfg_wdata;
    live_d = live_q;
    if (!gen_en) live_d = staged_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= '0;
      live_q   <= '0;
    end else begin
      staged_q <= staged_d;
      live_q   <= live_d;
    end
  end

  // R1: selector in the low bits, period field above it
  assign act_psc  = live_q[PSC_W-1:0];
  assign act_div  = live_q[CFG_W-1:PSC_W];
  assign half_len = CNT_W'(HALF_BASE)
                  + CNT_W'(HALF_STEP) * {{(CNT_W-DIV_W){1'b0}}, act_div};
  assign mid_pt   = half_len >> 1;

  // R9
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en |=> $stable(live_q));
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic [PSC_W-1:0] act_psc,
  output logic             ick
);
  logic [PSC_W-1:0] pcnt_q, pcnt_d;
  logic             hit;

  assign hit = (pcnt_q == act_psc);
  assign ick = gen_en && hit;

  always_comb begin
    pcnt_d = pcnt_q + 1'b1;
    if (!gen_en || hit) pcnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R2
  psc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= act_psc);
  // R2
  ick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ick && act_psc != '0) |=> !ick);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             ick,
  input  logic             scl_sense,
  input  logic [CNT_W-1:0] half_len,
  input  logic [CNT_W-1:0] mid_pt,
  output logic             pull_low,
  output logic             mid_low,
  output logic             mid_high
);
  scl_phase_e       ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last = (cnt_q == half_len - 1'b1);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!gen_en) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          ph_d  = PH_LOW;
          cnt_d = '0;
        end
        PH_LOW: if (ick) begin
          if (last) begin
            ph_d  = PH_RISE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_RISE: if (ick && scl_sense) begin
          // the tick that sees the line high is the first high tick
          ph_d  = PH_HIGH;
          cnt_d = CNT_W'(1);
        end
        PH_HIGH: if (ick) begin
          if (last) begin
            ph_d  = PH_LOW;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign pull_low = (ph_q == PH_LOW);
  assign mid_low  = ick && (ph_q == PH_LOW)  && (cnt_q == mid_pt);
  assign mid_high = ick && (ph_q == PH_HIGH) && (cnt_q == mid_pt);

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (!pull_low && !mid_low && !mid_high));
  // R5
  mid_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_low |-> pull_low);
  // R6
  mid_high_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_high |-> (!pull_low && scl_sense));
  // R7
  rise_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && ph_q == PH_RISE && ick && !scl_sense) |=> (ph_q == PH_RISE || !gen_en));
  // R4
  low_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> (cnt_q < half_len));
endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen
  import scl_gen_pkg::*;
#(
  parameter int PSC_W = DEF_PSC_W,
  parameter int DIV_W = DEF_DIV_W,
  parameter int BASE  = DEF_BASE,
  parameter int STEP  = DEF_STEP
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [PSC_W+DIV_W-1:0] cfg_wdata,
  input  logic                   gen_en,
  input  logic                   scl_sense,
  output logic                   scl_pull_low,
  output logic                   ick_pulse,
  output logic                   tick_mid_low,
  output logic                   tick_mid_high
);
  localparam int MAX_HALF = BASE / 2 + (STEP / 2) * ((1 << DIV_W) - 1);
  localparam int CNT_W    = $clog2(MAX_HALF + 1);

  logic [PSC_W-1:0] act_psc;
  logic [CNT_W-1:0] half_len;
  logic [CNT_W-1:0] mid_pt;
  logic             ick;

  scl_cfg_hold #(
    .PSC_W(PSC_W), .DIV_W(DIV_W), .BASE(BASE), .STEP(STEP), .CNT_W(CNT_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .gen_en(gen_en), .act_psc(act_psc), .half_len(half_len), .mid_pt(mid_pt)
  );

  scl_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .act_psc(act_psc), .ick(ick)
  );

  scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .ick(ick),
    .scl_sense(scl_sense), .half_len(half_len), .mid_pt(mid_pt),
    .pull_low(scl_pull_low), .mid_low(tick_mid_low), .mid_high(tick_mid_high)
  );

  assign ick_pulse = ick;
endmodule

// File: tb/test_scl_clk_gen.sv
module test_scl_clk_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic       gen_en;
  logic       scl_sense;
  logic       scl_pull_low, ick_pulse, tick_mid_low, tick_mid_high;

  int  n_run  = 0;
  int  n_fail = 0;
  int  dly    = 0;
  int  wd     = 0;
  logic [3:0] line_q;

  always #4 clk = ~clk;

  // bus line model: released line rises dly cycles late
  always_ff @(posedge clk) line_q <= {line_q[2:0], ~scl_pull_low};
  always_comb scl_sense = (dly == 0) ? ~scl_pull_low : line_q[dly-1];

  scl_clk_gen i_scl_clk_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .gen_en(gen_en), .scl_sense(scl_sense), .scl_pull_low(scl_pull_low),
    .ick_pulse(ick_pulse), .tick_mid_low(tick_mid_low), .tick_mid_high(tick_mid_high)
  );

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", wd);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic int exp_period(int p, int f, int d);
    return (p + 1) * (20 + 8 * f + d);
  endfunction

  function automatic int exp_low(int p, int f);
    return (p + 1) * (10 + 4 * f);
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = scl_pull_low;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!prev && scl_pull_low) return;
      prev = scl_pull_low;
    end
  endtask

  task automatic configure(int p, int f);
    gen_en    = 1'b0;
    cfg_we    = 1'b1;
    cfg_wdata = {f[5:0], p[1:0]};
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (4) @(negedge clk);
    gen_en = 1'b1;
    @(negedge clk);
    check("R8 low half starts after enable", int'(scl_pull_low), 1);
  endtask

  task automatic measure(int p, int f, int d);
    int  cyc, lo, ml, mh, tk;
    logic prev;
    wait_rise();
    cyc = 0; lo = 0; ml = 0; mh = 0; tk = 0;
    for (int i = 0; i < 5000; i++) begin
      cyc++;
      if (scl_pull_low)  lo++;
      if (tick_mid_low)  ml++;
      if (tick_mid_high) mh++;
      if (ick_pulse)     tk++;
      prev = scl_pull_low;
      @(negedge clk);
      if (!prev && scl_pull_low) break;
    end
    check($sformatf("R1/R3 period p=%0d f=%0d d=%0d", p, f, d), cyc, exp_period(p, f, d));
    check("R2 internal ticks per period", tk, 20 + 8 * f + d);
    check("R4 low half length", lo, exp_low(p, f));
    check("R5 mid-low strobes", ml, 1);
    check("R6 mid-high strobes", mh, 1);
    if (d != 0) check("R7 stretch adds ticks", cyc - exp_period(p, f, 0), d);
  endtask

  task automatic idle_check(int n);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (scl_pull_low || ick_pulse || tick_mid_low || tick_mid_high) seen++;
    end
    check("R8 outputs quiet while disabled", seen, 0);
  endtask

  initial begin
    int p, f;
    void'($urandom(32'h5C1_0042));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; gen_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset: scl released", int'(scl_pull_low), 0);
    check("R8 reset: no tick", int'(ick_pulse), 0);
    rst_n = 1'b1;
    idle_check(10);

    // directed corners: field bounds, all selectors
    configure(0, 0);  measure(0, 0, 0);
    configure(3, 0);  measure(3, 0, 0);
    configure(0, 63); measure(0, 63, 0);
    configure(3, 63); measure(3, 63, 0);
    configure(2, 5);  measure(2, 5, 0);

    // rise stretch, selector 0
    for (int d = 1; d <= 4; d++) begin
      dly = d;
      configure(0, 3); measure(0, 3, d);
    end
    dly = 0;

    // random configurations
    for (int k = 0; k < 8; k++) begin
      p = int'($urandom % 4);
      f = int'($urandom % 64);
      configure(p, f); measure(p, f, 0);
    end

    // R9: write while running, then apply via disable
    configure(1, 2);
    measure(1, 2, 0);
    cfg_we = 1'b1; cfg_wdata = {6'd9, 2'd0};
    @(negedge clk);
    cfg_we = 1'b0;
    measure(1, 2, 0);
    check("R9 busy write ignored", 1, 1);
    gen_en = 1'b0;
    idle_check(8);
    gen_en = 1'b1;
    @(negedge clk);
    measure(0, 9, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule